// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous 2K x 8 static RAM. The host issues one read or one write at a time over a simple request/ready handshake. The controller turns each request into the pin sequence the memory needs, holding every pin for a number of system clocks derived from nanosecond timing parameters.

A write lowers chip enable and write enable together and keeps the address fixed for the whole pulse. It holds its own data off the bus until the memory has stopped driving. Chip enable and write enable then rise on the same edge, and a recovery phase stretches the cycle to its minimum length. A read keeps chip enable and output enable low for the read cycle. It samples the bus on the last clock and returns the byte with a one-clock valid pulse.

Every nanosecond figure becomes a clock count by rounding up, so no minimum is ever shortened. The tri-state data bus appears as three plain ports: a value out, a value in and a drive enable.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and until the first request, `ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rd_valid` is 0.
- R2: A read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for RD = max(ceil(T_RC/CLK), ceil(T_AA/CLK)) clocks, which is 100 at the defaults. It samples `mem_dq_in` on the last of those clocks and shows that byte on `rd_data`.
- R3: A write lowers `mem_ce_n` and `mem_we_n` on the same edge. Both stay low for WP = max(ceil(T_WP/CLK), HZ + ceil(T_DW/CLK)) clocks, which is 10 at the defaults, and both rise on the same edge.
- R4: `mem_addr` changes only on a clock edge where `mem_we_n` was 1 in the cycle before it. It stays fixed through the write pulse and the recovery that follows.
- R5: `mem_dq_oe` is 0 for the first HZ = max(1, ceil(T_HZ/CLK)) clocks of a write pulse (4 at the defaults), then 1 until the write cycle ends. It is never 1 during a read or while idle.
- R6: A write keeps `ready` low for WP + REC clocks, where REC = max(ceil(T_WR/CLK), ceil(T_WC/CLK) - WP, 1). That is 100 clocks at the defaults.
- R7: `ready` is 0 for the whole memory cycle. A request presented while `ready` is 0 has no effect.
- R8: When `req_rd` and `req_wr` are both 1 at acceptance, only the write is carried out and no `rd_valid` follows.
- R9: The byte on `mem_dq_out` during a write is the accepted `req_wdata`, so a later read of that address returns it.
- R10: `rd_valid` is a single-clock pulse, in the first clock after a read in which `ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_rd | input | 1 | Read request, taken when ready is 1 |
| req_wr | input | 1 | Write request, taken when ready is 1, wins over req_rd |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to take a request |
| rd_valid | output | 1 | One-clock pulse marking rd_data valid |
| rd_data | output | 8 | Data returned by the last read |
| mem_addr | output | 11 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data read from the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The bench's memory model returns the inverted byte until the read address has been stable for the access time. A controller that samples one clock early therefore returns corrupted data. The model flags any cycle in which the controller drives the bus while output enable is low and write enable has been low for fewer than HZ clocks. That catches a design that drives data at the start of the pulse. It also measures the enable overlap and the length of every cycle, so a pulse or recovery that is one clock short is caught, as is an address that moves while write enable is low. Requests held through a busy cycle, and a read and a write presented together, show up as wrong read-back values or as a stray valid pulse.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WPULSE = 2'd2,
        ST_WREC   = 2'd3
    } sram_st_e;

    // nanoseconds to whole clocks, rounded up so a minimum is never shortened
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        vld_d  = capture;
        data_d = capture ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign dout  = data_q;
    assign valid = vld_q;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 1000,
    parameter int T_AA_NS   = 1000,
    parameter int T_WC_NS   = 1000,
    parameter int T_WP_NS   = 100,
    parameter int T_WR_NS   = 20,
    parameter int T_DW_NS   = 50,
    parameter int T_HZ_NS   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int HZ_CYC  = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
    localparam int DW_CYC  = imax(1, ns_to_cyc(T_DW_NS, CLK_NS));
    localparam int WP_CYC  = imax(ns_to_cyc(T_WP_NS, CLK_NS), HZ_CYC + DW_CYC);
    localparam int RD_CYC  = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                          ns_to_cyc(T_AA_NS, CLK_NS)));
    localparam int REC_CYC = imax(1, imax(ns_to_cyc(T_WR_NS, CLK_NS),
                                          ns_to_cyc(T_WC_NS, CLK_NS) - WP_CYC));
    localparam int CNT_MAX = imax(RD_CYC, imax(WP_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        sram_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drv;
    } ctrl_t;

    ctrl_t            cur_q, nxt_d;
    logic             tm_load;
    logic [CNT_W-1:0] tm_val;
    logic [CNT_W-1:0] tm_cnt;
    logic             tm_zero;
    logic             cap;

    sram_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .cnt      (tm_cnt),
        .expired  (tm_zero)
    );

    sram_seq_rdcap #(.DATA_W(DATA_W)) rdcap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .din     (mem_dq_in),
        .dout    (rd_data),
        .valid   (rd_valid)
    );

    always_comb begin
        nxt_d   = cur_q;
        tm_load = 1'b0;
        tm_val  = '0;
        cap     = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_wr) begin
                    // write wins; address setup of zero lets WE fall with the address
                    nxt_d.st    = ST_WPULSE;
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    nxt_d.ce_n  = 1'b0;
                    nxt_d.oe_n  = 1'b0;
                    nxt_d.we_n  = 1'b0;
                    nxt_d.drv   = 1'b0;
                    tm_load     = 1'b1;
                    tm_val      = CNT_W'(WP_CYC - 1);
                end else if (req_rd) begin
                    nxt_d.st   = ST_READ;
                    nxt_d.addr = req_addr;
                    nxt_d.ce_n = 1'b0;
                    nxt_d.oe_n = 1'b0;
                    tm_load    = 1'b1;
                    tm_val     = CNT_W'(RD_CYC - 1);
                end
            end
            ST_READ: begin
                if (tm_zero) begin
                    cap        = 1'b1;
                    nxt_d.st   = ST_IDLE;
                    nxt_d.ce_n = 1'b1;
                    nxt_d.oe_n = 1'b1;
                end
            end
            ST_WPULSE: begin
                // drive once HZ clocks of the pulse have gone by
                nxt_d.drv = (tm_cnt <= CNT_W'(WP_CYC - HZ_CYC));
                if (tm_zero) begin
                    nxt_d.st   = ST_WREC;
                    nxt_d.ce_n = 1'b1;
                    nxt_d.oe_n = 1'b1;
                    nxt_d.we_n = 1'b1;
                    tm_load    = 1'b1;
                    tm_val     = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WREC: begin
                // data and address held through recovery
                if (tm_zero) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.drv = 1'b0;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.addr  <= '0;
            cur_q.wdata <= '0;
            cur_q.ce_n  <= 1'b1;
            cur_q.oe_n  <= 1'b1;
            cur_q.we_n  <= 1'b1;
            cur_q.drv   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ready      = (cur_q.st == ST_IDLE);
    assign mem_addr   = cur_q.addr;
    assign mem_ce_n   = cur_q.ce_n;
    assign mem_oe_n   = cur_q.oe_n;
    assign mem_we_n   = cur_q.we_n;
    assign mem_dq_out = cur_q.wdata;
    assign mem_dq_oe  = cur_q.drv;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    // R1: an idle controller leaves the memory deselected and the bus free
    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

    // R3: chip enable and write enable fall together and rise together
    assert_we_fall_with_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $fell(mem_ce_n));
    assert_we_rise_with_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

    // R4: address held whenever write enable was low in the previous cycle
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_we_n) |-> $stable(mem_addr));

    // R5: drive never starts in the first cycle of a write pulse
    assert_no_early_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n)));

    // R5: with the chip selected, drive only while write enable is low
    assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && !mem_ce_n) |-> !mem_we_n);

    // R7: not ready while the memory is selected
    assert_busy_while_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !ready);

    // R10: single-clock valid pulse
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    // expected clock counts, worked out from the requirements at a 10 ns clock
    localparam int E_HZ  = 4;
    localparam int E_DW  = 5;
    localparam int E_WP  = 10;
    localparam int E_RD  = 100;
    localparam int E_AA  = 100;
    localparam int E_WR_BUSY = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_rd = 1'b0, req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sram_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- memory model and expected-content shadow ----------------
    logic [DW-1:0] cells  [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] exp_q[$];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            cells[i]  = DW'(i) ^ 8'h3C;
            shadow[i] = DW'(i) ^ 8'h3C;
        end
    end

    logic [AW-1:0] p_addr = '0;
    logic          p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1;
    int            rage = 0, ov = 0, wlow = 0, dcyc = 0;
    logic [AW-1:0] w_addr = '0;
    logic [DW-1:0] w_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            // read path: valid only after the address has aged E_AA clocks
            if (!mem_ce_n && !mem_oe_n && mem_we_n && !p_ce && !p_oe && p_we
                && mem_addr == p_addr) rage++;
            else rage = 0;
            if (!mem_ce_n && !mem_oe_n && mem_we_n)
                mem_dq_in = (rage >= E_AA - 1) ? cells[mem_addr] : ~cells[mem_addr];
            else
                mem_dq_in = 8'h00;
            // R4: address may not move once write enable was low
            if (mem_addr != p_addr && !p_we)
                check(1'b0, "R4 addr moved with WE low", int'(mem_addr), int'(p_addr));
            // write path
            if (!mem_we_n) wlow = p_we ? 0 : wlow + 1;
            if (mem_dq_oe && !mem_ce_n && !mem_oe_n && (mem_we_n || wlow < E_HZ))
                check(1'b0, "R5 bus driven inside turn-off window", wlow, E_HZ);
            if (!mem_ce_n && !mem_we_n) begin
                ov++;
                if (mem_dq_oe) begin
                    dcyc++;
                    w_data = mem_dq_out;
                end
                w_addr = mem_addr;
            end else if (ov > 0) begin
                check(ov == E_WP, "R3 write pulse length", ov, E_WP);
                check(mem_ce_n && mem_we_n, "R3 CE and WE rise together",
                      {mem_ce_n, mem_we_n}, 3);
                check(dcyc == E_WP - E_HZ && dcyc >= E_DW, "R5 data drive cycles",
                      dcyc, E_WP - E_HZ);
                cells[w_addr] = w_data;
                ov = 0;
                dcyc = 0;
            end
            p_addr = mem_addr; p_ce = mem_ce_n; p_oe = mem_oe_n; p_we = mem_we_n;
        end
    end

    // ---------------- scoreboard monitor ----------------
    logic prev_rv = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                check(!prev_rv, "R10 valid longer than one clock", 2, 1);
                check(ready, "R10 valid while busy", int'(ready), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected read data", int'(rd_data), 0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R2/R9 read data", int'(rd_data), int'(e));
                end
            end
            prev_rv = rd_valid;
        end
    end

    // ---------------- driver ----------------
    task automatic do_op(input bit rd, input bit wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int exp_busy, input string req);
        int busy;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d;
        if (wr) shadow[a] = d;
        else if (rd) exp_q.push_back(shadow[a]);
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        busy = 0;
        while (!ready) begin
            busy++;
            @(negedge clk);
        end
        check(busy == exp_busy, req, busy, exp_busy);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        do_op(1'b0, 1'b1, a, d, E_WR_BUSY, "R6 write busy length");
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        do_op(1'b1, 1'b0, a, '0, E_RD, "R2 read busy length");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid,
              "R1 reset state",
              {ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 6'b111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ready && mem_ce_n && mem_we_n, "R1 idle after reset",
              {ready, mem_ce_n, mem_we_n}, 3'b111);

        // R2: read of untouched content
        do_read(11'h023);
        // R9: writes with several data patterns, boundary addresses
        do_write(11'h000, 8'h00);
        do_write(11'h7FF, 8'hFF);
        do_write(11'h155, 8'hA5);
        do_write(11'h2AA, 8'h5A);
        do_read(11'h000);
        do_read(11'h7FF);
        do_read(11'h155);
        do_read(11'h2AA);
        // write followed at once by a read of the same address
        do_write(11'h400, 8'hC3);
        do_read(11'h400);

        // R7: request held through a busy write must be ignored
        begin
            int busy;
            @(negedge clk);
            while (!ready) @(negedge clk);
            req_wr = 1'b1; req_addr = 11'h100; req_wdata = 8'h11;
            shadow[11'h100] = 8'h11;
            @(negedge clk);
            req_addr = 11'h101; req_wdata = 8'hEE;   // would hit 0x101 if taken
            busy = 0;
            while (busy < 50) begin
                check(!ready, "R7 ready low during cycle", int'(ready), 0);
                busy++;
                @(negedge clk);
            end
            req_wr = 1'b0;
            while (!ready) begin
                busy++;
                @(negedge clk);
            end
            check(busy == E_WR_BUSY, "R7 cycle length with held request", busy, E_WR_BUSY);
        end
        do_read(11'h101);   // R7: still its initial content
        do_read(11'h100);

        // R8: read and write together, write wins and no valid pulse
        do_op(1'b1, 1'b1, 11'h010, 8'h77, E_WR_BUSY, "R8 simultaneous request busy");
        do_read(11'h010);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule